// File: doc/BRIEF.md
# Presettable Binary Counter with Gated Auto-Reload

The block is a synchronous up-counter, 8 bits wide by default, with a parallel preset. Every state change happens on the rising clock edge except the master clear, which acts at once without a clock. An active-low enable lets stages be chained. An active-low terminal-count flag marks the all-ones state and is the only output meant for driving the next stage of a chain.

A mode input selects between two behaviours. With the mode input low, the counter runs freely and wraps from all-ones to zero. With it high, reaching all-ones makes the counter reload its preset on the next advancing edge. With preset P, the block then divides the clock by 256 − P. The mode input has no internal pull, so a board that leaves it unused must tie it low.

A registered carry-out, with its complement, gives a clean one-clock pulse for each terminal-count event. It is meant for single-stage divider use and not for chaining.

Top module: `presettable_divider`

## Requirements
- R1: While `mclr` is high, `count` is 0, `cout` is 0 and `cout_n` is 1. The clear takes effect without waiting for a clock edge.
- R2: With `mclr` low, `pload` low and `en_n` low, each rising edge adds one to `count`, except in the cases covered by R5 and R6.
- R3: With `en_n` high and `pload` low, `count` keeps its value across clock edges.
- R4: `tc_n` is 0 exactly when `count` is all-ones (255 at the default width). This holds whatever the level of `en_n`.
- R5: With `tc_load` low, an enabled edge taken at all-ones moves `count` to 0.
- R6: With `tc_load` high, an enabled edge taken at all-ones loads `count` from `preset`.
- R7: With `tc_load` high and preset P, `tc_n` goes low once every 256 − P clocks. For P = 255, `tc_n` stays low on every clock.
- R8: With `pload` high, the next edge loads `preset` into `count`. This overrides both counting and hold.
- R9: `cout` is 1 for the single clock after each edge at which `count` was all-ones and `en_n` was low, and 0 otherwise. `cout_n` is always the complement of `cout`.
- R10: `mclr` overrides `pload`: a load requested during clear has no effect on `count`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counting clock, rising edge |
| mclr | input | 1 | Asynchronous master clear, active high |
| en_n | input | 1 | Count enable, active low |
| pload | input | 1 | Synchronous parallel load, active high |
| tc_load | input | 1 | Reload-at-terminal-count mode, tie low when unused |
| preset | input | WIDTH | Preset value for loads and reloads |
| count | output | WIDTH | Present count |
| tc_n | output | 1 | Terminal count, active low, for cascading |
| cout | output | 1 | Registered carry pulse |
| cout_n | output | 1 | Complement of cout |

## Verification
The bench builds the block at its default width of 8. At that width the all-ones state, the wrap and the reload are all reached within a few hundred clocks. Random loads of high preset values bring terminal-count events into the random phase often. Directed divide runs use presets 0, 100, 250 and 255, which cover the longest ratio of 256 and the degenerate ratio of 1.

// File: rtl/pdc_pkg.sv
package pdc_pkg;

    typedef enum logic [2:0] {
        OP_HOLD   = 3'd0,
        OP_INC    = 3'd1,
        OP_WRAP   = 3'd2,
        OP_RELOAD = 3'd3,
        OP_LOAD   = 3'd4
    } pdc_op_e;

    typedef struct packed {
        logic load;
        logic adv;
        logic auto_rl;
        logic at_max;
    } pdc_ctl_s;

    function automatic pdc_op_e pdc_decode(input pdc_ctl_s c);
        pdc_op_e op;
        if (c.load)
            op = OP_LOAD;
        else if (!c.adv)
            op = OP_HOLD;
        else if (c.at_max && c.auto_rl)
            op = OP_RELOAD;
        else if (c.at_max)
            op = OP_WRAP;
        else
            op = OP_INC;
        return op;
    endfunction

endpackage

// File: rtl/pdc_ctrl.sv
module pdc_ctrl
    import pdc_pkg::*;
(
    input  logic    pload,
    input  logic    en_n,
    input  logic    tc_load,
    input  logic    at_max,
    output pdc_op_e op,
    output logic    advance
);
    pdc_ctl_s ctl;

    always_comb begin
        ctl.load    = pload;
        ctl.adv     = ~en_n;
        ctl.auto_rl = tc_load;
        ctl.at_max  = at_max;
        op          = pdc_decode(ctl);
        advance     = ~en_n;
    end
endmodule

// File: rtl/pdc_datapath.sv
module pdc_datapath
    import pdc_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             mclr,
    input  pdc_op_e          op,
    input  logic [WIDTH-1:0] preset,
    output logic [WIDTH-1:0] count
);
    localparam logic [WIDTH-1:0] ZERO = '0;
    localparam logic [WIDTH-1:0] ONE  = WIDTH'(1);

    logic [WIDTH-1:0] nxt;

    always_comb begin
        unique case (op)
            OP_LOAD, OP_RELOAD: nxt = preset;
            OP_WRAP:            nxt = ZERO;
            OP_INC:             nxt = count + ONE;
            default:            nxt = count;
        endcase
    end

    always_ff @(posedge clk or posedge mclr) begin
        if (mclr)
            count <= ZERO;
        else
            count <= nxt;
    end
endmodule

// File: rtl/pdc_tcgen.sv
module pdc_tcgen #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             mclr,
    input  logic [WIDTH-1:0] count,
    input  logic             advance,
    output logic             at_max,
    output logic             tc_n,
    output logic             cout,
    output logic             cout_n
);
    localparam logic [WIDTH-1:0] ALL_ONES = '1;

    logic carry_q;

    always_comb begin
        at_max = (count == ALL_ONES);
        tc_n   = ~at_max;
    end

    always_ff @(posedge clk or posedge mclr) begin
        if (mclr)
            carry_q <= 1'b0;
        else
            carry_q <= at_max & advance;
    end

    always_comb begin
        cout   = carry_q;
        cout_n = ~carry_q;
    end
endmodule

// File: rtl/presettable_divider.sv
module presettable_divider
    import pdc_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             mclr,
    input  logic             en_n,
    input  logic             pload,
    input  logic             tc_load,
    input  logic [WIDTH-1:0] preset,
    output logic [WIDTH-1:0] count,
    output logic             tc_n,
    output logic             cout,
    output logic             cout_n
);
    pdc_op_e op;
    logic    advance;
    logic    at_max;

    pdc_ctrl u_ctrl (
        .pload   (pload),
        .en_n    (en_n),
        .tc_load (tc_load),
        .at_max  (at_max),
        .op      (op),
        .advance (advance)
    );

    pdc_datapath #(.WIDTH(WIDTH)) u_dp (
        .clk    (clk),
        .mclr   (mclr),
        .op     (op),
        .preset (preset),
        .count  (count)
    );

    pdc_tcgen #(.WIDTH(WIDTH)) u_tc (
        .clk     (clk),
        .mclr    (mclr),
        .count   (count),
        .advance (advance),
        .at_max  (at_max),
        .tc_n    (tc_n),
        .cout    (cout),
        .cout_n  (cout_n)
    );
endmodule

// File: rtl/pdc_checker.sv
module pdc_checker #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             mclr,
    input logic             en_n,
    input logic             pload,
    input logic             tc_load,
    input logic [WIDTH-1:0] preset,
    input logic [WIDTH-1:0] count,
    input logic             tc_n,
    input logic             cout,
    input logic             cout_n
);
    localparam logic [WIDTH-1:0] ALL_ONES = '1;

    // R1
    a_r1_clear_state: assert property (@(posedge clk)
        mclr |-> (count == '0 && !cout && cout_n));

    a_r2_increment: assert property (@(posedge clk) disable iff (mclr)
        (!pload && !en_n && tc_n) |=> (count == $past(count) + 1'b1));

    a_r3_hold: assert property (@(posedge clk) disable iff (mclr)
        (!pload && en_n) |=> $stable(count));

    a_r5_wrap: assert property (@(posedge clk) disable iff (mclr)
        (!pload && !en_n && !tc_load && !tc_n) |=> (count == '0));

    a_r6_reload: assert property (@(posedge clk) disable iff (mclr)
        (!pload && !en_n && tc_load && !tc_n) |=> (count == $past(preset)));

    a_r8_load: assert property (@(posedge clk) disable iff (mclr)
        pload |=> (count == $past(preset)));

    a_r9_carry_set: assert property (@(posedge clk) disable iff (mclr)
        (!tc_n && !en_n) |=> (cout && !cout_n));

    a_r9_carry_clr: assert property (@(posedge clk) disable iff (mclr)
        !(!tc_n && !en_n) |=> (!cout && cout_n));

    // R4: terminal flag agrees with the count seen at the port
    a_r4_tc_flag: assert property (@(posedge clk) disable iff (mclr)
        (count == ALL_ONES) == !tc_n);
endmodule

bind presettable_divider pdc_checker #(.WIDTH(WIDTH)) u_chk (
    .clk     (clk),
    .mclr    (mclr),
    .en_n    (en_n),
    .pload   (pload),
    .tc_load (tc_load),
    .preset  (preset),
    .count   (count),
    .tc_n    (tc_n),
    .cout    (cout),
    .cout_n  (cout_n)
);

// File: tb/presettable_divider_test.sv
module presettable_divider_test;
    localparam int W = 8;
    localparam logic [W-1:0] MAXV = '1;

    logic         clk = 1'b0;
    logic         mclr = 1'b1;
    logic         en_n = 1'b1;
    logic         pload = 1'b0;
    logic         tc_load = 1'b0;
    logic [W-1:0] preset = '0;
    logic [W-1:0] count;
    logic         tc_n, cout, cout_n;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [W-1:0] exp_cnt = '0;
    logic         exp_cout = 1'b0;
    string        cnt_tag = "R1 clear";

    always #2 clk = ~clk;

    presettable_divider #(.WIDTH(W)) uut (
        .clk(clk), .mclr(mclr), .en_n(en_n), .pload(pload),
        .tc_load(tc_load), .preset(preset), .count(count),
        .tc_n(tc_n), .cout(cout), .cout_n(cout_n)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [W-1:0] model_next(input logic [W-1:0] c,
            input logic pl, input logic en, input logic tl,
            input logic [W-1:0] pr, output string tag);
        if (pl) begin tag = "R8 load"; return pr; end
        if (en) begin tag = "R3 hold"; return c; end
        if (c == MAXV && tl) begin tag = "R6 reload"; return pr; end
        if (c == MAXV) begin tag = "R5 wrap"; return '0; end
        tag = "R2 increment";
        return c + 1'b1;
    endfunction

    // at a falling edge: check outputs, then apply the next inputs
    task automatic step(input logic pl, input logic en, input logic tl,
                        input logic [W-1:0] pr);
        string t;
        @(negedge clk);
        check(cnt_tag, count, exp_cnt);
        check("R4 tc_n", tc_n, (exp_cnt == MAXV) ? 0 : 1);
        check("R9 cout", cout, exp_cout);
        check("R9 cout_n", cout_n, !exp_cout);
        pload = pl; en_n = en; tc_load = tl; preset = pr;
        exp_cout = (exp_cnt == MAXV) && !en;
        exp_cnt  = model_next(exp_cnt, pl, en, tl, pr, t);
        cnt_tag  = t;
    endtask

    task automatic div_test(input logic [W-1:0] p);
        int last = -1;
        int ratio = 256 - int'(p);
        step(1'b1, 1'b0, 1'b1, p);
        for (int i = 0; i < 3 * ratio + 3; i++) begin
            step(1'b0, 1'b0, 1'b1, p);
            if (i > 0 && tc_n == 1'b0) begin
                if (last >= 0) check("R7 divide interval", i - last, ratio);
                last = i;
            end
        end
        check("R7 tc seen", (last >= 0) ? 1 : 0, 1);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        // R1 / R10: load requested while clear is held
        pload = 1'b1; preset = 8'h5A;
        repeat (3) @(negedge clk);
        check("R1 count at clear", count, 0);
        check("R10 load ignored in clear", count, 0);
        check("R1 cout_n at clear", cout_n, 1);
        mclr = 1'b0; pload = 1'b0;
        exp_cnt = '0; exp_cout = 1'b0; cnt_tag = "R1 clear";

        // directed: load near the top, free run through the wrap
        step(1'b1, 1'b1, 1'b0, 8'hFD);
        repeat (6) step(1'b0, 1'b0, 1'b0, 8'h00);
        // hold at all-ones: R4 flag persists with enable off
        step(1'b1, 1'b0, 1'b0, 8'hFF);
        repeat (3) step(1'b0, 1'b1, 1'b0, 8'h00);
        step(1'b0, 1'b0, 1'b0, 8'h00);

        // R7 divide ratios
        div_test(8'd0);
        div_test(8'd100);
        div_test(8'd250);
        div_test(8'd255);

        // constrained random
        for (int i = 0; i < 3000; i++) begin
            logic pl = ($urandom_range(0, 15) == 0);
            logic en = ($urandom_range(0, 7) == 0);
            logic tl = ($urandom_range(0, 1) == 1);
            logic [W-1:0] pr = ($urandom_range(0, 1) == 1) ?
                               W'($urandom_range(240, 255)) : W'($urandom);
            step(pl, en, tl, pr);
        end
        step(1'b0, 1'b1, 1'b0, 8'h00);

        // R1: asynchronous clear in mid-cycle
        @(negedge clk);
        #1 mclr = 1'b1;
        #0.5;
        check("R1 async clear count", count, 0);
        check("R1 async clear cout", cout, 0);
        @(negedge clk);
        mclr = 1'b0;
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                checks++; fails++;
                $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            end
        join_any
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule